// File: doc/BRIEF.md
# Serial Flag-Offset Register Loader

This block fills the four threshold registers of a pair of FIFOs after a master reset: an almost-full and an almost-empty offset for each of the two FIFOs. The values come in as a single bit stream on the write-side clock. A bit is taken on each clock edge where the active-low serial enable is asserted. The stream is one continuous shift of 48 bits, most significant bit first. The first register in the stream is the almost-full offset of FIFO one, then its almost-empty offset, then the almost-full offset of FIFO two, and last its almost-empty offset.

Serial loading is chosen by the levels on three pins during reset. The pin that carries serial data also serves as a mode strap while reset is held. In any other mode the four registers take a fixed default value and loading counts as finished immediately. Two hold-off outputs keep the input-ready flags of both FIFOs deasserted until loading is complete. One hold-off is released in the port A clock domain. The other is released in the port B clock domain after a two-stage synchronizer.

Top module: `offset_serial_loader`

## Requirements
- R1: Serial mode is selected only if, at the last port A clock edge while `rstN` is low, `cfgSel2`=0, `serData`=0 and `serEnN`=1. Any other combination selects default mode.
- R2: In serial mode, each port A edge with `serEnN`=0 shifts `serData` in as one bit, up to 48 bits in total. Edges with `serEnN`=1 leave every offset output unchanged.
- R3: The first bit received is the MSB of `yOff1`. Bits then fill `yOff1`, `xOff1`, `yOff2` and `xOff2`, each MSB first. The 48th bit is the LSB of `xOff2`.
- R4: In serial mode, `holdOffA` stays 1 and `loadDone` stays 0 until the 48th bit is taken. Both change on the next port A edge after the one that captures the 48th bit.
- R5: `holdOffB` falls on the second port B edge that samples `loadDone` high, and never earlier.
- R6: After 48 bits have been captured, further serial-enable pulses have no effect on the outputs until the next reset.
- R7: Each offset output reads in the range 1 to 4092. A received 0 reads as 1, and any value above 4092 reads as 4092.
- R8: In default mode, all four offsets read 8 and `loadDone` rises on the first port A edge after reset. Serial pulses have no effect.
- R9: While `rstN` is low, `loadDone`=0, `holdOffA`=1, `holdOffB`=1, and all offsets read the default value 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port A (write side) clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Master reset, active low, asynchronous assert |
| cfgSel2 | input | 1 | Mode strap sampled during reset |
| serData | input | 1 | Serial data bit; also a mode strap during reset |
| serEnN | input | 1 | Serial enable, active low; also a mode strap during reset |
| yOff1 | output | 12 | Almost-full offset, FIFO one |
| xOff1 | output | 12 | Almost-empty offset, FIFO one |
| yOff2 | output | 12 | Almost-full offset, FIFO two |
| xOff2 | output | 12 | Almost-empty offset, FIFO two |
| loadDone | output | 1 | Offset programming complete (port A domain) |
| holdOffA | output | 1 | Holds FIFO one input-ready low (port A domain) |
| holdOffB | output | 1 | Holds FIFO two input-ready low (port B domain) |

## Verification
Two events can share a single port A cycle: capture of the final bit, and a further enable pulse on the following edge, which lands in the same cycle that releases the hold-off. The bench provokes this by driving 54 bits back to back with no idle cycles, so the six surplus bits start right on top of the release. It judges the result by comparing all four offsets with the first 48 bits only. It also confirms that the release happens exactly one edge after the 48th capture.

// File: rtl/ofs_loader_pkg.sv
`timescale 1ns/1ps
package ofs_loader_pkg;
  // Strobes from the control unit to the shift datapath
  typedef struct packed {
    logic shift;        // take one serial bit this edge
    logic loadDefault;  // hold the fixed default pattern
  } ldStrobe_t;
endpackage

// File: rtl/ofs_ser_ctrl.sv
`timescale 1ns/1ps
module ofs_ser_ctrl
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int NUM_OFS = 4
) (
  input  logic      clkA,
  input  logic      rstN,
  input  logic      serData,
  input  logic      serEnN,
  input  logic      cfgSel2,
  output ldStrobe_t strobe,
  output logic      doneA
);
  localparam int TOTAL = OFS_W * NUM_OFS;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic             serialMode;
  logic [CNT_W-1:0] bitCnt;
  logic             full;

  // Mode strap: sampled on every edge while reset is held (R1)
  always_ff @(posedge clkA) begin
    if (!rstN) serialMode <= !cfgSel2 && !serData && serEnN;
  end

  assign full = (bitCnt == CNT_W'(TOTAL));

  always_comb begin
    strobe.shift       = rstN && serialMode && !serEnN && !full;
    strobe.loadDefault = rstN && !serialMode;
  end

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)             bitCnt <= '0;
    else if (strobe.shift) bitCnt <= bitCnt + 1'b1;
  end

  // Done rises one edge after the last bit lands (R4), or at once in default mode (R8)
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)           doneA <= 1'b0;
    else if (serialMode) doneA <= full;
    else                 doneA <= 1'b1;
  end

  // R2
  bit_cnt_bound_chk: assert property (@(posedge clkA) disable iff (!rstN)
    bitCnt <= CNT_W'(TOTAL));

  // R4
  done_rise_chk: assert property (@(posedge clkA) disable iff (!rstN)
    $rose(doneA) |-> (!serialMode || $past(full)));

  // R6
  done_sticky_chk: assert property (@(posedge clkA) disable iff (!rstN)
    doneA |=> doneA);

  // R6
  no_shift_after_done_chk: assert property (@(posedge clkA) disable iff (!rstN)
    doneA |-> !strobe.shift);
endmodule

// File: rtl/ofs_shift_dp.sv
`timescale 1ns/1ps
module ofs_shift_dp
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int NUM_OFS = 4,
  parameter int DEF_OFS = 8
) (
  input  logic                           clkA,
  input  logic                           rstN,
  input  logic                           serData,
  input  ldStrobe_t                      strobe,
  output logic [NUM_OFS-1:0][OFS_W-1:0]  ofsOut
);
  localparam int                 TOTAL   = OFS_W * NUM_OFS;
  localparam int                 OFS_MAX = (1 << OFS_W) - 4;
  localparam logic [OFS_W-1:0]   DEF_V   = OFS_W'(DEF_OFS);
  localparam logic [OFS_W-1:0]   MAX_V   = OFS_W'(OFS_MAX);
  localparam logic [TOTAL-1:0]   DEF_PAT = {NUM_OFS{DEF_V}};

  logic [TOTAL-1:0] shiftReg;

  // One continuous MSB-first shift; first bit ends in the top field (R3)
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)                    shiftReg <= DEF_PAT;
    else if (strobe.loadDefault)  shiftReg <= DEF_PAT;
    else if (strobe.shift)        shiftReg <= {shiftReg[TOTAL-2:0], serData};
  end

  // R2
  shift_hold_chk: assert property (@(posedge clkA) disable iff (!rstN)
    (!$past(strobe.shift) && !$past(strobe.loadDefault)) |-> $stable(shiftReg));

  for (genvar g = 0; g < NUM_OFS; g++) begin : gField
    logic [OFS_W-1:0] raw;
    assign raw = shiftReg[g*OFS_W +: OFS_W];
    always_comb begin
      if (raw == '0)        ofsOut[g] = OFS_W'(1);
      else if (raw > MAX_V) ofsOut[g] = MAX_V;
      else                  ofsOut[g] = raw;
    end

    // R7
    ofs_range_chk: assert property (@(posedge clkA) disable iff (!rstN)
      (ofsOut[g] != '0) && (ofsOut[g] <= MAX_V));
  end
endmodule

// File: rtl/ofs_done_sync.sv
`timescale 1ns/1ps
module ofs_done_sync (
  input  logic clkB,
  input  logic rstN,
  input  logic doneIn,
  output logic doneOut
);
  logic stage1;

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      stage1  <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      stage1  <= doneIn;
      doneOut <= stage1;
    end
  end

  // R5
  sync_cause_chk: assert property (@(posedge clkB) disable iff (!rstN)
    $rose(doneOut) |-> doneIn);

  // R5
  sync_sticky_chk: assert property (@(posedge clkB) disable iff (!rstN)
    doneOut |=> doneOut);
endmodule

// File: rtl/offset_serial_loader.sv
`timescale 1ns/1ps
module offset_serial_loader
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int DEF_OFS = 8
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             cfgSel2,
  input  logic             serData,
  input  logic             serEnN,
  output logic [OFS_W-1:0] yOff1,
  output logic [OFS_W-1:0] xOff1,
  output logic [OFS_W-1:0] yOff2,
  output logic [OFS_W-1:0] xOff2,
  output logic             loadDone,
  output logic             holdOffA,
  output logic             holdOffB
);
  localparam int NUM_OFS = 4;

  ldStrobe_t                        strobe;
  logic                             doneA;
  logic                             doneB;
  logic [NUM_OFS-1:0][OFS_W-1:0]    ofsOut;

  ofs_ser_ctrl #(.OFS_W(OFS_W), .NUM_OFS(NUM_OFS)) uCtrl (
    .clkA(clkA), .rstN(rstN), .serData(serData), .serEnN(serEnN),
    .cfgSel2(cfgSel2), .strobe(strobe), .doneA(doneA)
  );

  ofs_shift_dp #(.OFS_W(OFS_W), .NUM_OFS(NUM_OFS), .DEF_OFS(DEF_OFS)) uDp (
    .clkA(clkA), .rstN(rstN), .serData(serData), .strobe(strobe), .ofsOut(ofsOut)
  );

  ofs_done_sync uSync (
    .clkB(clkB), .rstN(rstN), .doneIn(doneA), .doneOut(doneB)
  );

  assign yOff1    = ofsOut[3];
  assign xOff1    = ofsOut[2];
  assign yOff2    = ofsOut[1];
  assign xOff2    = ofsOut[0];
  assign loadDone = doneA;
  assign holdOffA = !doneA;
  assign holdOffB = !doneB;
endmodule

// File: tb/sim_offset_serial_loader.sv
`timescale 1ns/1ps
module sim_offset_serial_loader;
  localparam real CLK_A_PERIOD = 10.0;
  localparam real CLK_B_HALF   = 6.3;
  localparam int  DEF          = 8;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic cfgSel2 = 1'b0, serData = 1'b0, serEnN = 1'b1;
  logic [11:0] yOff1, xOff1, yOff2, xOff2;
  logic loadDone, holdOffA, holdOffB;

  int errors = 0, checks = 0;
  int relEdges;

  always #(CLK_A_PERIOD/2) clkA = ~clkA;
  always #(CLK_B_HALF)     clkB = ~clkB;

  offset_serial_loader u0 (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .cfgSel2(cfgSel2),
    .serData(serData), .serEnN(serEnN), .yOff1(yOff1), .xOff1(xOff1),
    .yOff2(yOff2), .xOff2(xOff2), .loadDone(loadDone),
    .holdOffA(holdOffA), .holdOffB(holdOffB)
  );

  // Port B edges that have seen the port A release (model for R5)
  always @(posedge clkB or negedge rstN) begin
    if (!rstN) relEdges <= 0;
    else if (!holdOffA && relEdges < 7) relEdges <= relEdges + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampOf(input int v);
    if (v == 0) return 1;
    if (v > 4092) return 4092;
    return v;
  endfunction

  task automatic chkVals(input string req, input logic [47:0] v);
    chk(req, "yOff1", int'(yOff1), clampOf(int'(v[47:36])));
    chk(req, "xOff1", int'(xOff1), clampOf(int'(v[35:24])));
    chk(req, "yOff2", int'(yOff2), clampOf(int'(v[23:12])));
    chk(req, "xOff2", int'(xOff2), clampOf(int'(v[11:0])));
  endtask

  task automatic doReset(input logic s2, input logic sd, input logic en);
    @(negedge clkA);
    rstN = 1'b0; cfgSel2 = s2; serData = sd; serEnN = en;
    repeat (3) @(negedge clkA);
    rstN = 1'b1;
    cfgSel2 = 1'b0; serData = 1'b0; serEnN = 1'b1;
  endtask

  // Sends bits[n-1..0]; gap>0 inserts an idle cycle after every gap bits
  task automatic sendStream(input logic [63:0] bits, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clkA);
      serData = bits[n-1-i];
      serEnN  = 1'b0;
      if (gap > 0 && (i % gap) == gap-1 && i < n-1) begin
        @(negedge clkA);
        serEnN = 1'b1; serData = ~serData;
      end
    end
    @(negedge clkA);
    serEnN = 1'b1;
  endtask

  task automatic checkReleaseB();
    for (int i = 0; i < 6; i++) begin
      @(negedge clkB);
      chk("R5", "holdOffB", int'(holdOffB), (relEdges < 2) ? 1 : 0);
    end
  endtask

  // R9: values during reset
  task automatic testResetState();
    @(negedge clkA);
    rstN = 1'b0; cfgSel2 = 1'b0; serData = 1'b0; serEnN = 1'b1;
    repeat (3) @(negedge clkA);
    chk("R9", "loadDone in reset", int'(loadDone), 0);
    chk("R9", "holdOffA in reset", int'(holdOffA), 1);
    chk("R9", "holdOffB in reset", int'(holdOffB), 1);
    chk("R9", "yOff1 in reset", int'(yOff1), DEF);
    chk("R9", "xOff2 in reset", int'(xOff2), DEF);
    rstN = 1'b1;
  endtask

  // R1 R2 R3 R4 R5: load with gaps, release timing in both domains
  task automatic testSerialGaps();
    logic [47:0] v = {12'd100, 12'd37, 12'd4000, 12'd1};
    doReset(1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clkA);
    chk("R1", "serial mode keeps holdOffA", int'(holdOffA), 1);
    sendStream({16'h0, v} >> 1, 47, 3);
    chk("R4", "holdOffA after 47 bits", int'(holdOffA), 1);
    chk("R4", "loadDone after 47 bits", int'(loadDone), 0);
    sendStream({16'h0, v}, 1, 0);
    chk("R4", "holdOffA at capture edge", int'(holdOffA), 1);
    @(negedge clkA);
    chk("R4", "holdOffA one edge later", int'(holdOffA), 0);
    chk("R4", "loadDone one edge later", int'(loadDone), 1);
    checkReleaseB();
    chkVals("R3", v);
  endtask

  // R2: enable high with toggling data captures nothing
  task automatic testNoEnable();
    doReset(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clkA);
      serData = i[0];
    end
    chk("R2", "holdOffA without enable", int'(holdOffA), 1);
    chkVals("R2", {4{12'(DEF)}});
  endtask

  // R6: back-to-back surplus bits right at the release cycle
  task automatic testBackToBack();
    logic [47:0] v = {12'h5A5, 12'h3C3, 12'h0F1, 12'h777};
    doReset(1'b0, 1'b0, 1'b1);
    sendStream({10'h0, v, 6'b101010}, 54, 0);
    chk("R6", "loadDone after surplus", int'(loadDone), 1);
    chkVals("R6", v);
    sendStream(64'hFFFF_0000_FFFF_0000, 48, 0);
    chkVals("R6", v);
  endtask

  // R7: clamping of out-of-range values
  task automatic testClamp();
    logic [47:0] v = {12'd0, 12'd4095, 12'd4093, 12'd4092};
    doReset(1'b0, 1'b0, 1'b1);
    sendStream({16'h0, v}, 48, 5);
    @(negedge clkA);
    chk("R7", "yOff1 zero reads 1", int'(yOff1), 1);
    chk("R7", "xOff1 4095 reads 4092", int'(xOff1), 4092);
    chk("R7", "yOff2 4093 reads 4092", int'(yOff2), 4092);
    chk("R7", "xOff2 4092 kept", int'(xOff2), 4092);
  endtask

  // R1 R8: non-serial straps give defaults and immediate done
  task automatic testDefaultMode(input logic s2, input logic sd, input logic en);
    doReset(s2, sd, en);
    chk("R8", "loadDone before first edge", int'(loadDone), 0);
    @(negedge clkA);
    chk("R8", "loadDone after first edge", int'(loadDone), 1);
    chk("R8", "holdOffA after first edge", int'(holdOffA), 0);
    checkReleaseB();
    sendStream(64'h0000_1234_5678_9ABC, 48, 0);
    chkVals("R8", {4{12'(DEF)}});
  endtask

  initial begin
    fork
      begin
        #(CLK_A_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
      begin
        testResetState();
        testSerialGaps();
        testNoEnable();
        testBackToBack();
        testClamp();
        testDefaultMode(1'b1, 1'b0, 1'b1);
        testDefaultMode(1'b0, 1'b1, 1'b1);
        testDefaultMode(1'b0, 1'b0, 1'b0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule